// File: doc/BRIEF.md
# Strided Interleaved-Bank Access Sequencer

This block turns a single vector memory command into a stream of element accesses. A command has a base address, a signed stride and an element count. The block walks the addresses base, base + stride, base + 2·stride and so on. It splits each address into a bank number and a word-within-bank address for a low-order interleaved memory of `NUM_BANKS` banks.

Each bank stays occupied for `BUSY_CYC` cycles after it is accessed. The block keeps a countdown per bank to track this. It issues at most one element per cycle, strictly in order. It issues an element only when that element's bank is free, and raises a stall indication in any other running cycle. An odd stride visits every bank in turn and streams with no gaps. A stride that shares factors with the bank count folds onto fewer banks and stalls once it returns to a bank too soon. Bank occupancy carries over from one command to the next.

A one-cycle completion pulse follows the last element. The block then accepts the next command.

Top module: `strided_bank_access`

## Requirements
- R1: Element i of a command goes to address base + i·stride, where the 16-bit stride is sign-extended and the sum wraps modulo 2^32.
- R2: For each issued element, the bank output equals address bits [3:0] and the word output equals address bits [31:4].
- R3: Issue and stall are never high together, and neither is high while busy is low.
- R4: A bank accessed in cycle t is not accessed again before cycle t+4.
- R5: When start is seen while idle, busy is high from the next cycle. Element 0 issues in that cycle if its bank is free. Each later element issues in the first cycle after its predecessor in which its bank is free. A stalled element keeps its address.
- R6: An odd stride, when no bank is occupied at the start, issues one element every cycle with no stall.
- R7: A stride of 0 or a multiple of 16 sends every element to one bank, with issues exactly 4 cycles apart.
- R8: done is high for exactly one cycle, namely the cycle after the last element issues, and busy is low in that cycle.
- R9: A start seen while busy is ignored. The running command's addresses and timing are unchanged.
- R10: vec_len values 1 to 64 give that many elements. A value of 0 gives one element, and values above 64 give 64 elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command request, taken only while idle |
| base_addr | input | 32 | Address of element 0 |
| stride | input | 16 | Signed distance between successive elements |
| vec_len | input | 7 | Element count (0 means 1, above 64 means 64) |
| busy | output | 1 | A command is in progress |
| issue | output | 1 | The current element is sent to memory this cycle |
| stall | output | 1 | The current element waits on an occupied bank |
| bank | output | 4 | Bank of the current element |
| word_addr | output | 28 | Word within the bank of the current element |
| done | output | 1 | One-cycle pulse after the final element |

## Verification
The first element can appear in the cycle after the start edge. Element i appears at cycle t_i = max(t_{i-1}+1, previous use of its bank + 4) counted from there, and done follows exactly one cycle after the last t_i. Before raising start, the driver notes the cycle count and computes the whole schedule from the requirements. It pushes one item per element, each holding the bank, the word and the absolute cycle in which that element is due. The monitor samples at the falling edge. It pops one item per issue and compares the cycle as well as the address fields. When done arrives, the monitor checks the done cycle and the number of stall cycles.

// File: rtl/sab_pkg.sv
package sab_pkg;
    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_RUN  = 1'b1
    } ctl_mode_e;
endpackage

// File: rtl/sab_bank_timers.sv
module sab_bank_timers #(
    parameter int NUM_BANKS = 16,
    parameter int BUSY_CYC  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         hit_valid,
    input  logic [$clog2(NUM_BANKS)-1:0] hit_bank,
    output logic [NUM_BANKS-1:0]         bank_free
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int TW     = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;
    localparam logic [TW-1:0] RELOAD = TW'(BUSY_CYC - 1);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic [TW-1:0] cnt_d, cnt_q;
        logic          sel;

        always_comb begin
            sel = hit_valid && (hit_bank == BANK_W'(g));
            if (sel)
                cnt_d = RELOAD;
            else if (cnt_q != '0)
                cnt_d = cnt_q - 1'b1;
            else
                cnt_d = cnt_q;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign bank_free[g] = (cnt_q == '0);

        AST_NO_EARLY_REUSE: assert property (@(posedge clk) disable iff (!rst_n)
            sel |-> (cnt_q == '0)); // R4
    end
endmodule

// File: rtl/sab_addr_gen.sv
module sab_addr_gen #(
    parameter int ADDR_W   = 32,
    parameter int STRIDE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                step,
    input  logic [ADDR_W-1:0]   base,
    input  logic [STRIDE_W-1:0] stride,
    output logic [ADDR_W-1:0]   addr
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] inc;
    } ag_t;

    ag_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.addr = base;
            s_d.inc  = {{(ADDR_W-STRIDE_W){stride[STRIDE_W-1]}}, stride};
        end else if (step) begin
            s_d.addr = s_q.addr + s_q.inc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign addr = s_q.addr;

    AST_HOLD_WHEN_IDLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(addr)); // R5
endmodule

// File: rtl/strided_bank_access.sv
module strided_bank_access #(
    parameter int ADDR_W    = 32,
    parameter int STRIDE_W  = 16,
    parameter int NUM_BANKS = 16,
    parameter int BUSY_CYC  = 4,
    parameter int MAX_LEN   = 64
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start,
    input  logic [ADDR_W-1:0]                      base_addr,
    input  logic [STRIDE_W-1:0]                    stride,
    input  logic [$clog2(MAX_LEN+1)-1:0]           vec_len,
    output logic                                   busy,
    output logic                                   issue,
    output logic                                   stall,
    output logic [$clog2(NUM_BANKS)-1:0]           bank,
    output logic [ADDR_W-$clog2(NUM_BANKS)-1:0]    word_addr,
    output logic                                   done
);
    import sab_pkg::*;

    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int LEN_W  = $clog2(MAX_LEN + 1);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    typedef struct packed {
        ctl_mode_e        mode;
        logic [LEN_W-1:0] left;
        logic             done;
    } ctl_t;

    ctl_t              c_d, c_q;
    logic [LEN_W-1:0]  len_eff;
    logic              load;
    logic [ADDR_W-1:0] cur_addr;
    logic [NUM_BANKS-1:0] bank_free;
    logic              running;

    sab_addr_gen #(
        .ADDR_W  (ADDR_W),
        .STRIDE_W(STRIDE_W)
    ) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (issue),
        .base  (base_addr),
        .stride(stride),
        .addr  (cur_addr)
    );

    sab_bank_timers #(
        .NUM_BANKS(NUM_BANKS),
        .BUSY_CYC (BUSY_CYC)
    ) u_timers (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_valid(issue),
        .hit_bank (bank),
        .bank_free(bank_free)
    );

    always_comb begin
        if (vec_len == '0)
            len_eff = LEN_ONE;
        else if (vec_len > LEN_MAX)
            len_eff = LEN_MAX;
        else
            len_eff = vec_len;
    end

    assign running   = (c_q.mode == CTL_RUN);
    assign load      = start && !running;
    assign bank      = cur_addr[BANK_W-1:0];
    assign word_addr = cur_addr[ADDR_W-1:BANK_W];
    assign issue     = running && bank_free[bank];
    assign stall     = running && !bank_free[bank];
    assign busy      = running;
    assign done      = c_q.done;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        if (load) begin
            c_d.mode = CTL_RUN;
            c_d.left = len_eff;
        end else if (issue) begin
            c_d.left = c_q.left - 1'b1;
            if (c_q.left == LEN_ONE) begin
                c_d.mode = CTL_IDLE;
                c_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{mode: CTL_IDLE, left: '0, done: 1'b0};
        else        c_q <= c_d;
    end

    AST_ISSUE_STALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue && stall)); // R3
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue || stall) |-> busy); // R3
    AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(issue) && !busy)); // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !issue) |=> (busy && $stable(cur_addr))); // R9
    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (c_q.left != '0 && c_q.left <= LEN_MAX)); // R10
endmodule

// File: tb/sim_strided_bank_access.sv
`timescale 1ns/1ps
module sim_strided_bank_access;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base_addr = '0;
    logic [15:0] stride = '0;
    logic [6:0]  vec_len = '0;
    logic        busy, issue, stall, done;
    logic [3:0]  bank;
    logic [27:0] word_addr;

    always #2.5 clk = ~clk;

    strided_bank_access u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .stride(stride), .vec_len(vec_len), .busy(busy), .issue(issue),
        .stall(stall), .bank(bank), .word_addr(word_addr), .done(done)
    );

    typedef struct {
        int    bnk;
        int    wrd;
        int    at;
        bit    last;
        int    done_at;
        int    stalls;
        string tag;
    } exp_t;

    exp_t  q[$];
    int    pcyc = 0;
    int    nchk = 0;
    int    nfail = 0;
    int    ndone = 0;
    int    stall_cnt = 0;
    int    exp_done = -1;
    int    exp_stalls = 0;
    string exp_tag = "";
    bit    mon_en = 1'b0;
    bit    finished = 1'b0;

    always @(posedge clk) pcyc <= pcyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, pcyc);
        end
    endtask

    always @(negedge clk) begin
        if (mon_en) begin
            if (issue) begin
                if (q.size() == 0) begin
                    check(1'b0, "R9 issue with no element pending", 1, 0);
                end else begin
                    exp_t it;
                    it = q.pop_front();
                    check(int'(bank) == it.bnk, {it.tag, " R2 bank"}, int'(bank), it.bnk);
                    check(int'(word_addr) == it.wrd, {it.tag, " R1 R2 word"}, int'(word_addr), it.wrd);
                    check(pcyc == it.at, {it.tag, " R4 R5 issue cycle"}, pcyc, it.at);
                    if (it.last) begin
                        exp_done   = it.done_at;
                        exp_stalls = it.stalls;
                        exp_tag    = it.tag;
                    end
                end
            end
            if (stall) stall_cnt++;
            if (done) begin
                check(pcyc == exp_done, {exp_tag, " R8 done cycle"}, pcyc, exp_done);
                check(busy == 1'b0, {exp_tag, " R8 busy low at done"}, int'(busy), 0);
                check(stall_cnt == exp_stalls, {exp_tag, " stall count"}, stall_cnt, exp_stalls);
                stall_cnt = 0;
                ndone++;
            end
        end
    end

    task automatic run_cmd(input logic [31:0] b, input logic [15:0] s, input int len,
                           input string tag, input bit poke);
        int n, t, p, target;
        int last_t[16];
        logic [31:0] a;
        logic [31:0] sx;
        exp_t it;
        n = (len == 0) ? 1 : (len > 64 ? 64 : len);
        for (int k = 0; k < 16; k++) last_t[k] = -1000;
        sx = {{16{s[15]}}, s};
        @(negedge clk);
        p = pcyc;
        t = -1;
        for (int i = 0; i < n; i++) begin
            a = b + 32'(i) * sx;
            t = (t + 1 > last_t[a[3:0]] + 4) ? t + 1 : last_t[a[3:0]] + 4;
            last_t[a[3:0]] = t;
            it.bnk = int'(a[3:0]);
            it.wrd = int'(a[31:4]);
            it.at = p + 1 + t;
            it.last = (i == n - 1);
            it.done_at = p + 2 + t;
            it.stalls = t + 1 - n;
            it.tag = tag;
            q.push_back(it);
        end
        target = ndone + 1;
        base_addr = b; stride = s; vec_len = 7'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            base_addr = 32'h0000_0777; stride = 16'd7; vec_len = 7'd3; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (ndone == target);
        repeat (6) @(negedge clk);
        check(q.size() == 0, {tag, " R5 all elements issued"}, q.size(), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(busy == 0 && issue == 0 && stall == 0 && done == 0, "R3 R8 reset state",
              int'({busy, issue, stall, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && issue == 0, "R3 idle after reset", int'({busy, issue}), 0);
        mon_en = 1'b1;
        run_cmd(32'h0000_0100, 16'd1,      16, "R6 unit stride", 1'b0);
        run_cmd(32'h0000_0005, 16'd3,      20, "R6 odd stride 3", 1'b0);
        run_cmd(32'h0000_0040, 16'd16,      5, "R7 stride 16", 1'b0);
        run_cmd(32'h0000_0123, 16'd0,       4, "R7 stride 0", 1'b0);
        run_cmd(32'h0000_0002, 16'd8,       8, "R4 stride 8", 1'b0);
        run_cmd(32'h0000_0000, 16'd4,       8, "R4 stride 4", 1'b0);
        run_cmd(32'h0000_000A, 16'hFFFD,   10, "R1 negative stride wrap", 1'b0);
        run_cmd(32'hFFFF_FFF0, 16'd7,       6, "R1 top wrap", 1'b0);
        run_cmd(32'h0000_0200, 16'd5,       1, "R10 length 1", 1'b0);
        run_cmd(32'h0000_0300, 16'd5,      64, "R10 length 64", 1'b0);
        run_cmd(32'h0000_0400, 16'd2,       0, "R10 length 0", 1'b0);
        run_cmd(32'h0000_0500, 16'd1,     100, "R10 length clamp", 1'b0);
        run_cmd(32'h0000_0600, 16'd32,      6, "R9 start while busy", 1'b1);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule